// File: doc/BRIEF.md
# Colour Palette Sequenced Write Port

This block is the host-facing write side of a 256-entry colour lookup table. A host first loads an 8-bit entry pointer through the pointer register, then streams colour bytes into a single colour-data register. The bytes fill red, green and blue of the pointed entry in strict rotation, and once blue is stored the pointer moves on to the next entry, wrapping from 255 to 0. Many entries can therefore be loaded with one pointer write followed by a run of data writes.

A data access carries either one byte or a full 32-bit word. A word is cut into four bytes, taken from the most significant end down, and every byte steps the rotation. A colour triple may therefore start in one bus write and end in the next. All four bytes of a word are resolved and stored in the same clock cycle. A separate read port serves the pixel lookup path with one cycle of latency. A refresh-request flag tells the scanout logic that the table has changed, and it stays set until the scanout logic acknowledges it at the start of a frame.

Top module: `pal_wport`

## Requirements
- R1: Synchronous active-low reset clears all 768 colour bytes to zero, returns the rotation to red and sets `pal_dirty` to 1.
- R2: A valid write with `wr_sel`=0 loads `wr_data[7:0]` as the entry pointer and returns the rotation to red. It changes no colour byte and does not set `pal_dirty`.
- R3: With `wr_sel`=1 and `wr_size`=1, the byte `wr_data[7:0]` is stored into the red, green or blue byte of the pointed entry, according to the rotation state. The rotation then steps red to green, green to blue, or blue to red.
- R4: When a blue byte is stored, the pointer increments modulo 256, so that entry 255 is followed by entry 0.
- R5: With `wr_sel`=1 and `wr_size`=4, the word supplies four bytes in the order `wr_data[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. Each byte is handled as in R3 and R4, and the rotation and pointer state carry across bus writes.
- R6: `host_rdata` is zero at all times.
- R7: `pix_rgb` shows, one cycle after `pix_idx` is presented, the entry as {red[23:16], green[15:8], blue[7:0]}. If a write to the same entry happens in the cycle the index is sampled, `pix_rgb` shows the value the entry had before that write.
- R8: Every valid data write sets `pal_dirty` on the next edge. A `frame_ack` pulse clears it. The flag holds its value otherwise, and a data write in the same cycle as `frame_ack` leaves it set.
- R9: A write strobe whose `wr_size` is neither 1 nor 4 is ignored: the pointer, the rotation, the colour bytes and `pal_dirty` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Register select: 0 = entry pointer, 1 = colour data |
| wr_size | input | 3 | Byte count of the access (1 or 4 are valid) |
| wr_data | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (always zero) |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Registered lookup result {R,G,B} |
| frame_ack | input | 1 | One-cycle acknowledge from scanout, clears the dirty flag |
| pal_dirty | output | 1 | Palette changed, full refresh requested |

## Verification
The scanout read and the host write can hit the same entry in the same cycle. The bench provokes this by presenting `pix_idx` and a colour-data write to that entry on one edge. The scoreboard entry for that read was computed from the model before the write was applied, so it expects the old colour, and a follow-up read must return the new one. The bench also raises the refresh flag and `frame_ack` on one edge and expects the flag to stay set.

// File: rtl/pal_pkg.sv
// Package: shared types for the palette write port.
// Assumes three colour channels that are written in the fixed order red, green, blue.
package pal_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/pal_seq.sv
// Module: pal_seq
// Keeps the entry pointer and the colour rotation. For one access it works out
// which channel and which entry each byte lane writes.
// Assumes that byte_cnt is 1..LANES whenever data_wr is high, and that lanes are
// consumed in order starting at lane 0.
module pal_seq
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned CNT_W = $clog2(LANES + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              idx_load,
    input  logic [IDX_W-1:0]                  idx_val,
    input  logic                              data_wr,
    input  logic [CNT_W-1:0]                  byte_cnt,
    output logic [NUM_CH-1:0][LANES-1:0]      lane_we,
    output logic [LANES-1:0][IDX_W-1:0]       lane_idx
);
    phase_e           ph_q, ph_nx;
    logic [IDX_W-1:0] idx_q, idx_nx;

    // Walk the lanes in order and give each active lane a channel and an entry.
    always_comb begin
        phase_e           ph;
        logic [IDX_W-1:0] ix;
        ph       = ph_q;
        ix       = idx_q;
        lane_we  = '0;
        lane_idx = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_idx[k] = ix;
            if (data_wr && (k < int'(byte_cnt))) begin
                case (ph)
                    PH_RED: begin
                        lane_we[0][k] = 1'b1;
                        ph = PH_GRN;
                    end
                    PH_GRN: begin
                        lane_we[1][k] = 1'b1;
                        ph = PH_BLU;
                    end
                    default: begin
                        lane_we[2][k] = 1'b1;
                        ph = PH_RED;
                        ix = ix + 1'b1;
                    end
                endcase
            end
        end
        ph_nx  = ph;
        idx_nx = ix;
    end

    // Pointer and rotation state: a pointer load wins, a data write advances the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_RED;
            idx_q <= '0;
        end else if (idx_load) begin
            ph_q  <= PH_RED;
            idx_q <= idx_val;
        end else if (data_wr) begin
            ph_q  <= ph_nx;
            idx_q <= idx_nx;
        end
    end
endmodule

// File: rtl/pal_bank.sv
// Module: pal_bank
// One colour channel of the table, built from flip-flops. It takes up to LANES
// writes per cycle and has one registered read port.
// Assumes that active lanes in one cycle address distinct entries (the pointer
// advances between two writes to the same channel). A read returns the
// contents from before this cycle's writes.
module pal_bank #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            we,
    input  logic [LANES-1:0][IDX_W-1:0] widx,
    input  logic [LANES-1:0][DW-1:0]    wdat,
    input  logic [IDX_W-1:0]            ridx,
    output logic [DW-1:0]               rdat
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    // Storage update: clear everything on reset, otherwise apply each active lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                for (int k = 0; k < LANES; k++) begin
                    if (we[k] && (widx[k] == IDX_W'(e))) begin
                        mem[e] <= wdat[k];
                    end
                end
            end
        end
    end

    // Registered lookup that sees the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdat <= '0;
        end else begin
            rdat <= mem[ridx];
        end
    end
endmodule

// File: rtl/pal_flag.sv
// Module: pal_flag
// Refresh-request flag for the scanout logic. Set on any palette change,
// cleared by an acknowledge pulse; a change in the same cycle wins.
// Assumes reset should request a refresh, because the table was just cleared.
module pal_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set has priority over clear so that no change is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b1;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pal_wport.sv
// Module: pal_wport
// Top of the palette write port. It checks the access size and decodes the
// register select, slices a word into byte lanes (most significant first),
// and drives the sequencer, three channel banks and the refresh flag.
// Assumes that host reads of either register return zero and that wr_size
// counts bytes.
module pal_wport
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned CNT_W = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [CNT_W-1:0]      wr_size,
    input  logic [DW*LANES-1:0]   wr_data,
    output logic [DW*LANES-1:0]   host_rdata,
    input  logic [IDX_W-1:0]      pix_idx,
    output logic [NUM_CH*DW-1:0]  pix_rgb,
    input  logic                  frame_ack,
    output logic                  pal_dirty
);
    localparam logic [CNT_W-1:0] SZ_BYTE = CNT_W'(1);
    localparam logic [CNT_W-1:0] SZ_WORD = CNT_W'(LANES);

    logic                              acc_ok;
    logic                              idx_load;
    logic                              data_wr;
    logic [CNT_W-1:0]                  byte_cnt;
    logic [LANES-1:0][DW-1:0]          lane_dat;
    logic [NUM_CH-1:0][LANES-1:0]      lane_we;
    logic [LANES-1:0][IDX_W-1:0]       lane_idx;
    logic [NUM_CH-1:0][DW-1:0]         ch_rd;

    // Access qualification: only byte and full-word accesses take effect.
    always_comb begin
        acc_ok   = wr_en && ((wr_size == SZ_BYTE) || (wr_size == SZ_WORD));
        idx_load = acc_ok && !wr_sel;
        data_wr  = acc_ok && wr_sel;
        byte_cnt = (wr_size == SZ_WORD) ? SZ_WORD : SZ_BYTE;
    end

    // Lane slicing: for a word, lane 0 carries the most significant byte.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            if (wr_size == SZ_WORD) begin
                lane_dat[k] = wr_data[(LANES-1-k)*DW +: DW];
            end else begin
                lane_dat[k] = wr_data[DW-1:0];
            end
        end
    end

    assign host_rdata = '0;

    pal_seq #(
        .IDX_W (IDX_W),
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (idx_load),
        .idx_val  (wr_data[IDX_W-1:0]),
        .data_wr  (data_wr),
        .byte_cnt (byte_cnt),
        .lane_we  (lane_we),
        .lane_idx (lane_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pal_bank #(
            .IDX_W (IDX_W),
            .DW    (DW),
            .LANES (LANES)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[c]),
            .widx  (lane_idx),
            .wdat  (lane_dat),
            .ridx  (pix_idx),
            .rdat  (ch_rd[c])
        );
        // Channel 0 (red) lands in the top byte of the lookup result.
        assign pix_rgb[(NUM_CH-1-c)*DW +: DW] = ch_rd[c];
    end

    pal_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (data_wr),
        .clr_i  (frame_ack),
        .flag_o (pal_dirty)
    );
endmodule

// File: rtl/pal_wport_chk.sv
// Module: pal_wport_chk
// Port-level properties of pal_wport. It is attached to every instance by the
// bind below and only observes.
module pal_wport_chk #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned CNT_W = $clog2(LANES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_sel,
    input logic [CNT_W-1:0]     wr_size,
    input logic [DW*LANES-1:0]  wr_data,
    input logic [DW*LANES-1:0]  host_rdata,
    input logic [IDX_W-1:0]     pix_idx,
    input logic [3*DW-1:0]      pix_rgb,
    input logic                 frame_ack,
    input logic                 pal_dirty
);
    logic       ok_sz;
    logic [1:0] age;

    assign ok_sz = (wr_size == CNT_W'(1)) || (wr_size == CNT_W'(LANES));

    // Count edges since reset so that $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && ok_sz) |=> pal_dirty); // R8

    AST_DIRTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ack && !(wr_en && wr_sel && ok_sz)) |=> !pal_dirty); // R8

    AST_DIRTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_dirty && !frame_ack) |=> pal_dirty); // R8

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ok_sz && !pal_dirty) |=> !pal_dirty); // R9

    AST_IDX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !pal_dirty) |=> !pal_dirty); // R2

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && ($past(pix_idx) == $past(pix_idx, 2)) && !$past(wr_en, 2))
        |-> (pix_rgb == $past(pix_rgb))); // R7
endmodule

bind pal_wport pal_wport_chk #(
    .IDX_W (IDX_W),
    .DW    (DW),
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/pal_wport_tb.sv
// Scoreboard bench for pal_wport. Driver tasks update a reference model and
// queue the lookups they expect; a monitor pops the queue at the negative edge.
module pal_wport_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [2:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        frame_ack = 1'b0;
    logic        pal_dirty;

    typedef struct {
        int          due;
        logic [23:0] exp;
        string       rq;
    } item_t;

    item_t      sb_q[$];
    int         cyc = 0;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_idx = '0;
    int         m_ph = 0;
    logic       m_dirty = 1'b1;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pal_wport u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_size    (wr_size),
        .wr_data    (wr_data),
        .host_rdata (host_rdata),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb),
        .frame_ack  (frame_ack),
        .pal_dirty  (pal_dirty)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Move to just after the next rising edge and drop the one-cycle strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        wr_en     = 1'b0;
        frame_ack = 1'b0;
    endtask

    task automatic do_write(bit sel, logic [2:0] size, logic [31:0] data);
        logic [7:0] bt;
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_size = size;
        wr_data = data;
        if (size == 3'd1 || size == 3'd4) begin
            if (!sel) begin
                m_idx = data[7:0];
                m_ph  = 0;
            end else begin
                m_dirty = 1'b1;
                for (int b = 0; b < int'(size); b++) begin
                    bt = (size == 3'd4) ? data[31-8*b -: 8] : data[7:0];
                    case (m_ph)
                        0: m_r[m_idx] = bt;
                        1: m_g[m_idx] = bt;
                        default: begin
                            m_b[m_idx] = bt;
                            m_idx = m_idx + 8'd1;
                        end
                    endcase
                    m_ph = (m_ph + 1) % 3;
                end
            end
        end
    endtask

    // Queue a lookup; the expected value reflects writes already issued.
    task automatic pix_rd(logic [7:0] idx, string rq);
        item_t it;
        pix_idx = idx;
        it.due  = cyc + 1;
        it.exp  = {m_r[idx], m_g[idx], m_b[idx]};
        it.rq   = rq;
        sb_q.push_back(it);
    endtask

    task automatic ack();
        frame_ack = 1'b1;
        m_dirty   = 1'b0;
    endtask

    task automatic chk_dirty(string rq);
        chk(rq, {31'd0, pal_dirty}, {31'd0, m_dirty});
    endtask

    task automatic rd_tick(logic [7:0] idx, string rq);
        pix_rd(idx, rq);
        tick();
    endtask

    // Monitor: compare due lookups and the host read data.
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.rq, {8'd0, pix_rgb}, {8'd0, it.exp});
            end
            if (host_rdata !== 32'd0) begin
                chk("R6 host_rdata", host_rdata, 32'd0);
            end
        end
    end

    initial begin
        #(4 * 60000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 256; i++) begin
            m_r[i] = '0;
            m_g[i] = '0;
            m_b[i] = '0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state.
        chk_dirty("R1 dirty after reset");
        chk("R6 host_rdata", host_rdata, 32'd0);
        rd_tick(8'd0, "R1 entry 0");
        rd_tick(8'd128, "R1 entry 128");
        rd_tick(8'd255, "R1 entry 255");
        // R8: acknowledge clears the flag.
        ack();
        tick();
        chk_dirty("R8 ack clears");
        // R2: a pointer write does not set the flag.
        do_write(1'b0, 3'd1, 32'h0000_0005);
        tick();
        chk_dirty("R2 pointer write leaves flag");
        // R3, R4: byte writes rotate and advance the pointer.
        do_write(1'b1, 3'd1, 32'hAA);
        tick();
        chk_dirty("R8 data write sets");
        do_write(1'b1, 3'd1, 32'hBB);
        tick();
        do_write(1'b1, 3'd1, 32'hCC);
        tick();
        do_write(1'b1, 3'd1, 32'hDD);
        tick();
        rd_tick(8'd5, "R3 entry 5 rgb");
        rd_tick(8'd6, "R4 next entry red");
        // R2: a pointer rewrite mid-triple restarts at red.
        do_write(1'b0, 3'd1, 32'd10);
        tick();
        do_write(1'b1, 3'd1, 32'h11);
        tick();
        do_write(1'b1, 3'd1, 32'h22);
        tick();
        do_write(1'b0, 3'd1, 32'd10);
        tick();
        do_write(1'b1, 3'd1, 32'h33);
        tick();
        rd_tick(8'd10, "R2 phase restart");
        // R4: wrap from 255 to 0.
        do_write(1'b0, 3'd4, 32'h0000_00FF);
        tick();
        do_write(1'b1, 3'd1, 32'h01);
        tick();
        do_write(1'b1, 3'd1, 32'h02);
        tick();
        do_write(1'b1, 3'd1, 32'h03);
        tick();
        do_write(1'b1, 3'd1, 32'h04);
        tick();
        rd_tick(8'd255, "R4 entry 255");
        rd_tick(8'd0, "R4 wrap to 0");
        // R5: word writes, a triple spanning two words.
        do_write(1'b0, 3'd1, 32'd20);
        tick();
        do_write(1'b1, 3'd4, 32'h1122_3344);
        tick();
        do_write(1'b1, 3'd4, 32'h5566_7788);
        tick();
        rd_tick(8'd20, "R5 word entry 20");
        rd_tick(8'd21, "R5 split triple entry 21");
        rd_tick(8'd22, "R5 entry 22 partial");
        // R9: illegal sizes are ignored.
        ack();
        tick();
        do_write(1'b1, 3'd2, 32'hDEAD_BEEF);
        tick();
        chk_dirty("R9 size 2 ignored flag");
        do_write(1'b0, 3'd0, 32'd99);
        tick();
        do_write(1'b1, 3'd3, 32'h1234_5678);
        tick();
        chk_dirty("R9 size 3 ignored flag");
        rd_tick(8'd22, "R9 entry 22 unchanged");
        rd_tick(8'd99, "R9 entry 99 unchanged");
        do_write(1'b1, 3'd1, 32'h9A);
        tick();
        rd_tick(8'd22, "R9 state kept blue lands 22");
        // R7: same-cycle read and write of one entry returns the old value.
        do_write(1'b0, 3'd1, 32'd30);
        tick();
        pix_rd(8'd30, "R7 collision old value");
        do_write(1'b1, 3'd4, 32'hF1F2_F3F4);
        tick();
        rd_tick(8'd30, "R7 new value after");
        // R8: set wins over a same-cycle acknowledge.
        ack();
        do_write(1'b1, 3'd1, 32'h55);
        tick();
        chk_dirty("R8 set beats ack");
        // R3, R5: pseudo-random mixed traffic, then a full sweep.
        lf = 32'hACE1_2345;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3:0] == 4'd0) begin
                do_write(1'b0, 3'd1, {24'd0, lf[15:8]});
            end else begin
                do_write(1'b1, lf[4] ? 3'd4 : 3'd1, lf);
            end
            tick();
        end
        for (int i = 0; i < 256; i++) begin
            rd_tick(8'(i), "R3 R5 sweep");
        end
        repeat (3) tick();
        chk("R7 queue drained", sb_q.size(), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule